// File: doc/BRIEF.md
# Violation Interrupt MSI Register Block

This block keeps the error-notification settings of an I/O memory protection checker and turns rule-violation pulses into interrupts. Software reaches one configuration word and two MSI address registers through a plain 32-bit register port. Reads on that port are combinational and writes take effect on the clock edge.

The configuration word holds a sticky lock, an interrupt enable, a response-suppress select, an MSI enable and an 11-bit MSI data value. When a violation pulse arrives with interrupts enabled, one of two things happens. If MSI is enabled, the block raises a single posted write request that carries the data word and the configured address, and holds it until it is acknowledged. If MSI is disabled, the block sets a level interrupt output that stays high until software clears it.

The parameter `HI_ADDR_EN` selects whether a high address register exists. This changes how the low register is read into the target address. The MSI enable bit can be writable or fixed by parameters.

Top module: `vmsi_regblk`

## Requirements
- R1: After reset, lock, interrupt enable, response suppress, MSI data and both address registers are 0. MSI enable is 0 when writable, or `MSI_EN_VAL` when fixed. `msi_req` and `irq_level` are low.
- R2: The configuration word is at offset 0x60 and has these fields: bit 0 lock, bit 1 interrupt enable, bit 2 response suppress, bit 3 MSI enable, bits 18:8 MSI data. Bits 7:4 and 31:19 always read 0, and writing them has no effect. An unmapped offset reads 0.
- R3: Writing 1 to bit 0 of 0x60 sets the lock in the same write. Writing 0 never clears it, and only reset clears it.
- R4: While the lock is 1, writes to 0x60, 0x78 (low address) and 0x7C (high address) are ignored.
- R5: `rsp_suppress` follows bit 2 of the configuration word. A value of 0 selects an error response and 1 selects a success response with a predefined value.
- R6: While MSI enable is 0, reads of 0x78, 0x7C and the MSI data field return 0. Writes to 0x78 and 0x7C are discarded. A configuration write updates MSI data only when the MSI enable that results from that write is 1.
- R7: With `MSI_EN_HARD`=1, MSI enable always reads `MSI_EN_VAL`, and writes to bit 3 have no effect.
- R8: With `HI_ADDR_EN`=1, the target address is {high, low}. With `HI_ADDR_EN`=0, the low register supplies address bits 33:2, bits 1:0 are zero, and 0x7C reads 0.
- R9: A violation pulse with interrupt enable 1 and MSI enable 1 raises `msi_req` on the next cycle. The address is captured at that edge, and `msi_data` is the MSI data zero-extended to 32 bits.
- R10: `msi_req` and its address and data stay unchanged until an edge with `msi_ack` high, after which `msi_req` falls. Violations while a request is pending, including in the acknowledge cycle, are merged into that request.
- R11: A violation pulse with interrupt enable 1 and MSI enable 0 sets `irq_level` on the next cycle. `irq_clr` clears it, and a violation in the same cycle as `irq_clr` wins.
- R12: With interrupt enable 0, a violation pulse changes neither `msi_req` nor `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| viol_pulse | input | 1 | Rule-violation pulse |
| rsp_suppress | output | 1 | Response-suppress select |
| msi_req | output | 1 | MSI write request |
| msi_ack | input | 1 | Acknowledge for the MSI write |
| msi_addr | output | 64 | MSI target byte address |
| msi_data | output | 32 | MSI write data |
| irq_level | output | 1 | Level interrupt used when MSI is off |
| irq_clr | input | 1 | Clears `irq_level` |

## Verification
The hardest situation to reach is a pending MSI request meeting other events in the same cycle. These include a fresh violation together with the acknowledge, an address rewrite while the request waits, and a locked configuration that must still launch a request. The stimulus reaches it by pulsing `viol_pulse` in the acknowledge cycle and rewriting the low address before the acknowledge. Writes to the address registers while MSI is off are also checked later through reads once MSI is on. A second instance, with no high register and a fixed MSI enable, covers the shifted address form.

// File: rtl/vmsi_pkg.sv
package vmsi_pkg;
   localparam int unsigned MD_W   = 11;
   localparam int unsigned MD_LSB = 8;
   localparam int unsigned OFF_CFG = 32'h60;
   localparam int unsigned OFF_LO  = 32'h78;
   localparam int unsigned OFF_HI  = 32'h7C;
   localparam int unsigned B_LOCK = 0;
   localparam int unsigned B_IE   = 1;
   localparam int unsigned B_RS   = 2;
   localparam int unsigned B_ME   = 3;

   typedef struct packed {
      logic            lock;
      logic            ie;
      logic            rs;
      logic            me;
      logic [MD_W-1:0] md;
   } cfg_t;
endpackage

// File: rtl/vmsi_cfg_regs.sv
module vmsi_cfg_regs
   import vmsi_pkg::*;
#(
   parameter bit          HI_ADDR_EN  = 1'b1,
   parameter bit          MSI_EN_HARD = 1'b0,
   parameter bit          MSI_EN_VAL  = 1'b0,
   parameter int unsigned REG_AW      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   output cfg_t              cfg,
   output logic [31:0]       addr_lo,
   output logic [31:0]       addr_hi
);
   localparam logic [REG_AW-1:0] A_CFG = REG_AW'(OFF_CFG);
   localparam logic [REG_AW-1:0] A_LO  = REG_AW'(OFF_LO);
   localparam logic [REG_AW-1:0] A_HI  = REG_AW'(OFF_HI);

   logic wr_ok, wr_cfg, wr_lo, wr_hi, me_nxt;

   assign wr_ok  = wr && !cfg.lock;
   assign wr_cfg = wr_ok && (addr == A_CFG);
   assign wr_lo  = wr_ok && cfg.me && (addr == A_LO);
   assign wr_hi  = wr_ok && cfg.me && (addr == A_HI);

   generate
      if (MSI_EN_HARD) begin : g_me_fixed
         assign cfg.me = MSI_EN_VAL;
         assign me_nxt = MSI_EN_VAL;
         logic unused_wbit;
         assign unused_wbit = wdata[B_ME];
      end else begin : g_me_rw
         logic me_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      me_q <= 1'b0;
            else if (wr_cfg) me_q <= wdata[B_ME];
         end
         assign cfg.me = me_q;
         assign me_nxt = wr_cfg ? wdata[B_ME] : me_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.lock <= 1'b0;
         cfg.ie   <= 1'b0;
         cfg.rs   <= 1'b0;
         cfg.md   <= '0;
      end else if (wr_cfg) begin
         cfg.lock <= wdata[B_LOCK];
         cfg.ie   <= wdata[B_IE];
         cfg.rs   <= wdata[B_RS];
         if (me_nxt) cfg.md <= wdata[MD_LSB +: MD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     addr_lo <= '0;
      else if (wr_lo) addr_lo <= wdata;
   end

   generate
      if (HI_ADDR_EN) begin : g_hi
         logic [31:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_hi) hi_q <= wdata;
         end
         assign addr_hi = hi_q;
      end else begin : g_no_hi
         assign addr_hi = '0;
         logic unused_hi;
         assign unused_hi = wr_hi;
      end
   endgenerate

   assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.lock |=> cfg.lock);
   assert_locked_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.lock |=> ($stable(cfg) && $stable(addr_lo) && $stable(addr_hi)));
   assert_addr_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.me |=> ($stable(addr_lo) && $stable(addr_hi)));
endmodule

// File: rtl/vmsi_notify.sv
module vmsi_notify
   import vmsi_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            viol,
   input  logic            ie,
   input  logic            me,
   input  logic [63:0]     tgt_addr,
   input  logic [MD_W-1:0] md,
   input  logic            ack,
   input  logic            clr,
   output logic            req,
   output logic [63:0]     req_addr,
   output logic [31:0]     req_data,
   output logic            irq
);
   logic fire_msi, fire_irq;
   assign fire_msi = viol && ie && me;
   assign fire_irq = viol && ie && !me;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req      <= 1'b0;
         req_addr <= '0;
         req_data <= '0;
      end else if (req) begin
         if (ack) req <= 1'b0;
      end else if (fire_msi) begin
         req      <= 1'b1;
         req_addr <= tgt_addr;
         req_data <= 32'(md);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        irq <= 1'b0;
      else if (fire_irq) irq <= 1'b1;
      else if (clr)      irq <= 1'b0;
   end

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(req_addr) && $stable(req_data)));
   assert_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && !fire_msi) |=> !req);
   assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);
   assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie && !req && !irq) |=> (!req && !irq));
endmodule

// File: rtl/vmsi_regblk.sv
module vmsi_regblk
   import vmsi_pkg::*;
#(
   parameter bit          HI_ADDR_EN  = 1'b1,
   parameter bit          MSI_EN_HARD = 1'b0,
   parameter bit          MSI_EN_VAL  = 1'b0,
   parameter int unsigned REG_AW      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              viol_pulse,
   output logic              rsp_suppress,
   output logic              msi_req,
   input  logic              msi_ack,
   output logic [63:0]       msi_addr,
   output logic [31:0]       msi_data,
   output logic              irq_level,
   input  logic              irq_clr
);
   generate
      if (REG_AW < 7) begin : g_bad_aw
         $error("vmsi_regblk: REG_AW too small for the register offsets");
      end
   endgenerate

   localparam logic [REG_AW-1:0] A_CFG = REG_AW'(OFF_CFG);
   localparam logic [REG_AW-1:0] A_LO  = REG_AW'(OFF_LO);
   localparam logic [REG_AW-1:0] A_HI  = REG_AW'(OFF_HI);

   cfg_t        cfg;
   logic [31:0] lo, hi;
   logic [63:0] tgt;

   vmsi_cfg_regs #(
      .HI_ADDR_EN (HI_ADDR_EN),
      .MSI_EN_HARD(MSI_EN_HARD),
      .MSI_EN_VAL (MSI_EN_VAL),
      .REG_AW     (REG_AW)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .cfg    (cfg),
      .addr_lo(lo),
      .addr_hi(hi)
   );

   generate
      if (HI_ADDR_EN) begin : g_tgt_wide
         assign tgt = {hi, lo};
      end else begin : g_tgt_word
         assign tgt = {30'b0, lo, 2'b00};
      end
   endgenerate

   vmsi_notify u_notify (
      .clk     (clk),
      .rst_n   (rst_n),
      .viol    (viol_pulse),
      .ie      (cfg.ie),
      .me      (cfg.me),
      .tgt_addr(tgt),
      .md      (cfg.md),
      .ack     (msi_ack),
      .clr     (irq_clr),
      .req     (msi_req),
      .req_addr(msi_addr),
      .req_data(msi_data),
      .irq     (irq_level)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CFG) begin
         reg_rdata[B_LOCK]           = cfg.lock;
         reg_rdata[B_IE]             = cfg.ie;
         reg_rdata[B_RS]             = cfg.rs;
         reg_rdata[B_ME]             = cfg.me;
         reg_rdata[MD_LSB +: MD_W]   = cfg.me ? cfg.md : '0;
      end else if (reg_addr == A_LO) begin
         reg_rdata = cfg.me ? lo : '0;
      end else if (reg_addr == A_HI) begin
         reg_rdata = cfg.me ? hi : '0;
      end
   end

   assign rsp_suppress = cfg.rs;

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CFG) |-> (reg_rdata[31:19] == '0 && reg_rdata[7:4] == '0));
   assert_unavail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[B_ME] && reg_addr == A_CFG) |-> (reg_rdata[18:8] == '0));
endmodule

// File: tb/vmsi_regblk_tb.sv
module vmsi_regblk_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        reg_wr = 0, viol = 0, ack = 0, clr = 0;
   logic [7:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] rdata;
   logic        rsp, req, irq;
   logic [63:0] maddr;
   logic [31:0] mdata;

   logic        b_wr = 0, b_viol = 0, b_ack = 0;
   logic [7:0]  b_addr = 0;
   logic [31:0] b_wd = 0, b_rdata, b_mdata;
   logic        b_rsp, b_req, b_irq;
   logic [63:0] b_maddr;

   int total = 0, bad = 0, cyc = 0;

   vmsi_regblk dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata), .viol_pulse(viol),
      .rsp_suppress(rsp), .msi_req(req), .msi_ack(ack), .msi_addr(maddr),
      .msi_data(mdata), .irq_level(irq), .irq_clr(clr));

   vmsi_regblk #(.HI_ADDR_EN(1'b0), .MSI_EN_HARD(1'b1), .MSI_EN_VAL(1'b1)) dut_b (
      .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_addr(b_addr),
      .reg_wdata(b_wd), .reg_rdata(b_rdata), .viol_pulse(b_viol),
      .rsp_suppress(b_rsp), .msi_req(b_req), .msi_ack(b_ack), .msi_addr(b_maddr),
      .msi_data(b_mdata), .irq_level(b_irq), .irq_clr(1'b0));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference for dut_i
   bit m_l, m_ie, m_rs, m_me, m_req, m_irq;
   bit [10:0] m_md;
   bit [31:0] m_lo, m_hi, m_data;
   bit [63:0] m_addr;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_l = 0; m_ie = 0; m_rs = 0; m_me = 0; m_md = 0; m_lo = 0; m_hi = 0;
         m_req = 0; m_irq = 0; m_addr = 0; m_data = 0;
      end else begin
         if (m_req) begin
            if (ack) m_req = 0;
         end else if (viol && m_ie && m_me) begin
            m_req = 1; m_addr = {m_hi, m_lo}; m_data = {21'b0, m_md};
         end
         if (viol && m_ie && !m_me) m_irq = 1;
         else if (clr) m_irq = 0;
         if (reg_wr && !m_l) begin
            if (reg_addr == 8'h60) begin
               m_ie = reg_wdata[1]; m_rs = reg_wdata[2];
               if (reg_wdata[3]) m_md = reg_wdata[18:8];
               m_me = reg_wdata[3]; m_l = reg_wdata[0];
            end else if (reg_addr == 8'h78 && m_me) m_lo = reg_wdata;
            else if (reg_addr == 8'h7C && m_me) m_hi = reg_wdata;
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a == 8'h60) return {13'b0, (m_me ? m_md : 11'b0), 4'b0, m_me, m_rs, m_ie, m_l};
      if (a == 8'h78) return m_me ? m_lo : 32'h0;
      if (a == 8'h7C) return m_me ? m_hi : 32'h0;
      return 32'h0;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 rdata", {32'h0, rdata}, {32'h0, m_read(reg_addr)});
         chk("R5 rsp", {63'h0, rsp}, {63'h0, m_rs});
         chk("R10 req", {63'h0, req}, {63'h0, m_req});
         chk("R11 irq", {63'h0, irq}, {63'h0, m_irq});
         if (m_req) begin
            chk("R9 addr", maddr, m_addr);
            chk("R9 data", {32'h0, mdata}, {32'h0, m_data});
         end
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(); reg_wr = 1; reg_addr = a; reg_wdata = d;
      step(); reg_wr = 0;
   endtask
   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a; @(negedge clk);
      chk(tag, {32'h0, rdata}, {32'h0, exp});
   endtask
   task automatic pulse();
      step(); viol = 1; step(); viol = 0;
   endtask
   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      step(); b_wr = 1; b_addr = a; b_wd = d;
      step(); b_wr = 0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      rd(8'h60, 32'h0, "R1 cfg reset");
      rd(8'h78, 32'h0, "R1 lo reset");
      chk("R1 req reset", {63'h0, req}, 64'h0);
      chk("R1 irq reset", {63'h0, irq}, 64'h0);
      // msi off: data and address writes discarded
      wr(8'h60, 32'hFFF8_5AF2);
      rd(8'h60, 32'h0000_0002, "R6 cfg with msi off");
      wr(8'h78, 32'h1234_5678);
      wr(8'h7C, 32'h1111_2222);
      // wired interrupt path
      pulse(); @(negedge clk);
      chk("R11 irq set", {63'h0, irq}, 64'h1);
      step(); clr = 1; viol = 1; step(); clr = 0; viol = 0; @(negedge clk);
      chk("R11 set beats clear", {63'h0, irq}, 64'h1);
      step(); clr = 1; step(); clr = 0; @(negedge clk);
      chk("R11 irq cleared", {63'h0, irq}, 64'h0);
      // enable msi, all fields
      wr(8'h60, 32'hFFFF_FFFE);
      rd(8'h60, 32'h0007_FF0E, "R2 cfg layout");
      chk("R5 suppress", {63'h0, rsp}, 64'h1);
      rd(8'h78, 32'h0, "R6 lo write discarded while off");
      rd(8'h7C, 32'h0, "R6 hi write discarded while off");
      wr(8'h78, 32'h1234_5678);
      wr(8'h7C, 32'hABCD_0001);
      rd(8'h7C, 32'hABCD_0001, "R8 hi readback");
      rd(8'h40, 32'h0, "R2 unmapped");
      pulse(); @(negedge clk);
      chk("R9 req", {63'h0, req}, 64'h1);
      chk("R9 addr", maddr, 64'hABCD_0001_1234_5678);
      chk("R9 data", {32'h0, mdata}, 64'h7FF);
      wr(8'h78, 32'h0);
      @(negedge clk);
      chk("R10 addr held", maddr, 64'hABCD_0001_1234_5678);
      pulse(); @(negedge clk);
      chk("R10 merged", {63'h0, req}, 64'h1);
      step(); ack = 1; viol = 1; step(); ack = 0; viol = 0; @(negedge clk);
      chk("R10 drop after ack", {63'h0, req}, 64'h0);
      // interrupt enable off
      wr(8'h60, 32'h0007_FF08);
      pulse(); @(negedge clk); @(negedge clk);
      chk("R12 no req", {63'h0, req}, 64'h0);
      chk("R12 no irq", {63'h0, irq}, 64'h0);
      // lock
      wr(8'h60, 32'h0000_0A0B);
      rd(8'h60, 32'h0000_0A0B, "R3 lock set");
      wr(8'h60, 32'h0);
      rd(8'h60, 32'h0000_0A0B, "R3 R4 lock sticky, cfg frozen");
      wr(8'h78, 32'hFFFF_FFFF);
      rd(8'h78, 32'h0, "R4 lo frozen");
      wr(8'h7C, 32'h0);
      rd(8'h7C, 32'hABCD_0001, "R4 hi frozen");
      pulse(); @(negedge clk);
      chk("R9 locked req", {63'h0, req}, 64'h1);
      chk("R9 locked data", {32'h0, mdata}, 64'hA);
      step(); ack = 1; step(); ack = 0;
      // second configuration: no high register, fixed msi enable
      @(negedge clk);
      b_addr = 8'h60; @(negedge clk);
      chk("R7 R1 fixed enable at reset", {32'h0, b_rdata}, 64'h8);
      bwr(8'h60, 32'h0000_1232);
      b_addr = 8'h60; @(negedge clk);
      chk("R7 enable ignores write", {32'h0, b_rdata}, 64'h120A);
      bwr(8'h78, 32'h4000_0001);
      bwr(8'h7C, 32'h5555_5555);
      b_addr = 8'h7C; @(negedge clk);
      chk("R8 no high register", {32'h0, b_rdata}, 64'h0);
      step(); b_viol = 1; step(); b_viol = 0; @(negedge clk);
      chk("R8 shifted addr", b_maddr, 64'h0000_0001_0000_0004);
      chk("R9 data b", {32'h0, b_mdata}, 64'h12);
      step(); b_ack = 1; step(); b_ack = 0; @(negedge clk);
      chk("R10 b released", {63'h0, b_req}, 64'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc > 20000);
      bad++; total++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule